// File: doc/BRIEF.md
# CCD Horizontal Clamp and Blanking Sequencer

This block drives two per-pixel control strobes for a CCD readout front end: a clamp strobe that marks optical-black reference pixels for the black-level loop, and a blanking strobe that marks pixels carrying no usable data. It tracks where the readout is inside the current line and inside the current frame. From the line position it picks one of three horizontal patterns: a blanking pattern, a whole-line clamp pattern, or an image pattern that clamps only on the dark pixels at the end of each line.

A line is laid out as dummy pixels, then a few leading dark pixels, then the effective pixels, then a run of trailing dark pixels. A frame starts with a group of dark lines. The effective image lines follow, and a short group of trailing dark lines closes the frame. The effective pixel and line counts are parameters, and so is every other segment length. The system supplies a line-start pulse at the first pixel of each line and a frame-start pulse with the first line of each frame. A single configuration bit chooses whether the trailing dark lines use the clamp pattern or the blanking pattern.

Top module: `ccd_hseq_ctrl`

## Requirements
- R1: After reset, and until the first frame_start, seq_sel is 1, clamp_ob is 0 and pix_blank is 1 on every cycle, even when line_start pulses arrive. A reset in mid-frame returns the block to this state.
- R2: The outputs are registered. When line_start is sampled high at a clock edge, the outputs for pixel 0 of the new line appear right after that edge. Pixel p appears p cycles later.
- R3: A frame_start sampled together with a line_start makes that line index 0. Each line_start without frame_start advances the index by one. The index saturates one past the last line, so every later line uses sequence 1.
- R4: seq_sel encodes the sequence: 2'd1 is blanking, 2'd2 is the dark-line clamp and 2'd3 is image. Indices 0 to LEAD_OB_LINES-1 use 2'd2. The next ACTIVE_LINES indices use 2'd3. The TAIL_OB_LINES indices after those depend on R8, and every index past them uses 2'd1. seq_sel is never 2'd0.
- R5: While seq_sel is 1, clamp_ob is 0 and pix_blank is 1 for every pixel.
- R6: While seq_sel is 2, clamp_ob is 1 and pix_blank is 0 for every pixel of the line.
- R7: While seq_sel is 3, pix_blank is 0. clamp_ob is 1 exactly for the pixel indices from DUMMY_PIX+LEAD_OB_PIX+ACTIVE_PIX up to one below the line length, which are the trailing dark pixels. It is 0 for every other pixel.
- R8: With tail_ob_seq2_en at 1, the trailing dark lines use sequence 2. With it at 0, they use sequence 1. The bit is sampled on every clock edge together with the counters.
- R9: Without a new line_start, the pixel position stops at the line length. In sequence 3, clamp_ob then stays 0 and all outputs hold steady.
- R10: A frame_start in the middle of a frame restarts the frame at line index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle pulse marking the first pixel of a line |
| frame_start | input | 1 | One-cycle pulse given with the line_start of a frame's first line |
| tail_ob_seq2_en | input | 1 | 1: trailing dark lines use the clamp pattern; 0: blanking pattern |
| clamp_ob | output | 1 | Optical-black clamp strobe, registered |
| pix_blank | output | 1 | Pixel blanking strobe, registered |
| seq_sel | output | 2 | Active horizontal sequence (1, 2 or 3), registered |

## Verification
The embedded properties check the following on every cycle: the strobe pair implied by each sequence value, that clamping in image lines stays inside the trailing dark window, the region-to-sequence mapping and the tail configuration against the line counter, the counter restarts on the two pulses, and the forced blanking pattern before a frame starts. Some behaviour only the bench's scenarios can show. These are the exact cycle in which a new line's pattern appears after its pulse, the full sequence order across several frames (one with the tail clamp enabled, one with it disabled, and one restarted mid-frame), the saturated hold after an overlong line, and recovery from a mid-frame reset.

// File: rtl/ccd_hseq_pkg.sv
package ccd_hseq_pkg;

    typedef enum logic [1:0] {
        SEQ_NONE  = 2'd0,
        SEQ_BLANK = 2'd1,
        SEQ_VOB   = 2'd2,
        SEQ_IMAGE = 2'd3
    } hseq_e;

    typedef struct packed {
        logic  clamp;
        logic  blank;
        hseq_e seq;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{clamp: 1'b0, blank: 1'b1, seq: SEQ_BLANK};

    // Choose a horizontal sequence from the vertical position of the line.
    function automatic hseq_e pick_seq(
        input logic        valid,
        input int unsigned line,
        input int unsigned lead_lines,
        input int unsigned act_lines,
        input int unsigned tail_lines,
        input logic        tail_en
    );
        if (!valid)
            return SEQ_BLANK;
        if (line < lead_lines)
            return SEQ_VOB;
        if (line < lead_lines + act_lines)
            return SEQ_IMAGE;
        if (line < lead_lines + act_lines + tail_lines)
            return tail_en ? SEQ_VOB : SEQ_BLANK;
        return SEQ_BLANK;
    endfunction

    // Strobe levels for one pixel under a given sequence.
    function automatic strobe_t strobe_for(
        input hseq_e       seq,
        input int unsigned pix,
        input int unsigned tail_lo,
        input int unsigned line_len
    );
        strobe_t s;
        s.seq = seq;
        unique case (seq)
            SEQ_VOB: begin
                s.clamp = 1'b1;
                s.blank = 1'b0;
            end
            SEQ_IMAGE: begin
                s.clamp = (pix >= tail_lo) && (pix < line_len);
                s.blank = 1'b0;
            end
            default: begin
                s.seq   = SEQ_BLANK;
                s.clamp = 1'b0;
                s.blank = 1'b1;
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ccd_hseq_pix_ctr.sv
module ccd_hseq_pix_ctr #(
    parameter int LINE_LEN = 96,
    parameter int PW       = $clog2(LINE_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_start,
    output logic [PW-1:0] pix_nxt,
    output logic [PW-1:0] pix_q
);

    localparam logic [PW-1:0] PIX_END = PW'(LINE_LEN);

    always_comb begin
        if (line_start)
            pix_nxt = '0;
        else if (pix_q == PIX_END)
            pix_nxt = pix_q;
        else
            pix_nxt = pix_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pix_q <= PIX_END;
        else
            pix_q <= pix_nxt;
    end

    // R2: a line pulse makes the next position pixel 0
    assert_pix_restart_R2: assert property (@(posedge clk) disable iff (rst)
        line_start |=> (pix_q == '0));

    // R9: the position never runs past the end of the line
    assert_pix_range_R9: assert property (@(posedge clk) disable iff (rst)
        pix_q <= PIX_END);

endmodule

// File: rtl/ccd_hseq_line_ctr.sv
module ccd_hseq_line_ctr #(
    parameter int NUM_LINES = 15,
    parameter int LW        = $clog2(NUM_LINES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_start,
    input  logic          frame_start,
    output logic [LW-1:0] line_nxt,
    output logic [LW-1:0] line_q,
    output logic          valid_nxt,
    output logic          valid_q
);

    localparam logic [LW-1:0] LINE_END = LW'(NUM_LINES);

    always_comb begin
        valid_nxt = valid_q | frame_start;
        if (frame_start)
            line_nxt = '0;
        else if (line_start && (line_q != LINE_END))
            line_nxt = line_q + 1'b1;
        else
            line_nxt = line_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q  <= LINE_END;
            valid_q <= 1'b0;
        end else begin
            line_q  <= line_nxt;
            valid_q <= valid_nxt;
        end
    end

    // R3 / R10: a frame pulse restarts the frame at line 0
    assert_frame_restart_R10: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (line_q == '0) && valid_q);

    // R3: the line index saturates one past the last line
    assert_line_range_R3: assert property (@(posedge clk) disable iff (rst)
        line_q <= LINE_END);

endmodule

// File: rtl/ccd_hseq_strobe_gen.sv
module ccd_hseq_strobe_gen
    import ccd_hseq_pkg::*;
#(
    parameter int PW         = 7,
    parameter int LW         = 4,
    parameter int LEAD_LINES = 10,
    parameter int ACT_LINES  = 3,
    parameter int TAIL_LINES = 2,
    parameter int TAIL_LO    = 48,
    parameter int LINE_LEN   = 96
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] pix_nxt,
    input  logic [LW-1:0] line_nxt,
    input  logic          valid_nxt,
    input  logic          tail_en,
    output strobe_t       strobe_q
);

    hseq_e   seq_nxt;
    strobe_t strobe_nxt;

    always_comb begin
        seq_nxt    = pick_seq(valid_nxt, 32'(line_nxt), LEAD_LINES, ACT_LINES,
                              TAIL_LINES, tail_en);
        strobe_nxt = strobe_for(seq_nxt, 32'(pix_nxt), TAIL_LO, LINE_LEN);
    end

    always_ff @(posedge clk) begin
        if (rst)
            strobe_q <= STROBE_IDLE;
        else
            strobe_q <= strobe_nxt;
    end

    // R4: the encoding 2'd0 is never produced
    assert_seq_legal_R4: assert property (@(posedge clk) disable iff (rst)
        strobe_q.seq != SEQ_NONE);

endmodule

// File: rtl/ccd_hseq_ctrl.sv
module ccd_hseq_ctrl
    import ccd_hseq_pkg::*;
#(
    parameter int DUMMY_PIX     = 28,
    parameter int LEAD_OB_PIX   = 4,
    parameter int ACTIVE_PIX    = 640,
    parameter int TAIL_OB_PIX   = 48,
    parameter int LEAD_OB_LINES = 10,
    parameter int ACTIVE_LINES  = 480,
    parameter int TAIL_OB_LINES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_start,
    input  logic       frame_start,
    input  logic       tail_ob_seq2_en,
    output logic       clamp_ob,
    output logic       pix_blank,
    output logic [1:0] seq_sel
);

    localparam int TAIL_LO    = DUMMY_PIX + LEAD_OB_PIX + ACTIVE_PIX;
    localparam int LINE_LEN   = TAIL_LO + TAIL_OB_PIX;
    localparam int IMG_FIRST  = LEAD_OB_LINES;
    localparam int TAIL_FIRST = LEAD_OB_LINES + ACTIVE_LINES;
    localparam int NUM_LINES  = TAIL_FIRST + TAIL_OB_LINES;
    localparam int PW         = $clog2(LINE_LEN + 1);
    localparam int LW         = $clog2(NUM_LINES + 1);

    logic [PW-1:0] pix_nxt, pix_q;
    logic [LW-1:0] line_nxt, line_q;
    logic          valid_nxt, frame_valid;
    strobe_t       strobe_q;

    ccd_hseq_pix_ctr #(
        .LINE_LEN (LINE_LEN),
        .PW       (PW)
    ) u_pix (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .pix_nxt    (pix_nxt),
        .pix_q      (pix_q)
    );

    ccd_hseq_line_ctr #(
        .NUM_LINES (NUM_LINES),
        .LW        (LW)
    ) u_line (
        .clk         (clk),
        .rst         (rst),
        .line_start  (line_start),
        .frame_start (frame_start),
        .line_nxt    (line_nxt),
        .line_q      (line_q),
        .valid_nxt   (valid_nxt),
        .valid_q     (frame_valid)
    );

    ccd_hseq_strobe_gen #(
        .PW         (PW),
        .LW         (LW),
        .LEAD_LINES (LEAD_OB_LINES),
        .ACT_LINES  (ACTIVE_LINES),
        .TAIL_LINES (TAIL_OB_LINES),
        .TAIL_LO    (TAIL_LO),
        .LINE_LEN   (LINE_LEN)
    ) u_strobe (
        .clk       (clk),
        .rst       (rst),
        .pix_nxt   (pix_nxt),
        .line_nxt  (line_nxt),
        .valid_nxt (valid_nxt),
        .tail_en   (tail_ob_seq2_en),
        .strobe_q  (strobe_q)
    );

    assign clamp_ob  = strobe_q.clamp;
    assign pix_blank = strobe_q.blank;
    assign seq_sel   = strobe_q.seq;

    // R1: no frame yet, so only the blanking pattern is allowed
    assert_preframe_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !frame_valid |-> (seq_sel == SEQ_BLANK) && !clamp_ob && pix_blank);

    // R5: blanking pattern strobes
    assert_blank_pattern_R5: assert property (@(posedge clk) disable iff (rst)
        (seq_sel == SEQ_BLANK) |-> !clamp_ob && pix_blank);

    // R6: whole-line clamp on dark lines
    assert_vob_pattern_R6: assert property (@(posedge clk) disable iff (rst)
        (seq_sel == SEQ_VOB) |-> clamp_ob && !pix_blank);

    // R7: image-line clamp confined to the trailing dark pixels
    assert_image_clamp_R7: assert property (@(posedge clk) disable iff (rst)
        ((seq_sel == SEQ_IMAGE) && clamp_ob) |->
            (32'(pix_q) >= TAIL_LO) && (32'(pix_q) < LINE_LEN));

    assert_image_noblank_R7: assert property (@(posedge clk) disable iff (rst)
        (seq_sel == SEQ_IMAGE) |-> !pix_blank);

    // R4: leading dark lines and image lines map to their sequences
    assert_lead_region_R4: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && (32'(line_q) < IMG_FIRST)) |-> (seq_sel == SEQ_VOB));

    assert_image_region_R4: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && (32'(line_q) >= IMG_FIRST) && (32'(line_q) < TAIL_FIRST))
            |-> (seq_sel == SEQ_IMAGE));

    // R8: trailing dark lines follow the configuration bit
    assert_tail_cfg_R8: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && (32'(line_q) >= TAIL_FIRST) && (32'(line_q) < NUM_LINES))
            |-> (seq_sel == ($past(tail_ob_seq2_en) ? SEQ_VOB : SEQ_BLANK)));

    // R3: past the last line only blanking remains
    assert_after_frame_R3: assert property (@(posedge clk) disable iff (rst)
        (32'(line_q) == NUM_LINES) |-> (seq_sel == SEQ_BLANK));

endmodule

// File: tb/ccd_hseq_ctrl_bench.sv
`timescale 1ns/1ps
module ccd_hseq_ctrl_bench;

    localparam int DUMMY = 28;
    localparam int LEADP = 4;
    localparam int ACTP  = 16;
    localparam int TAILP = 48;
    localparam int LEADL = 10;
    localparam int ACTL  = 3;
    localparam int TAILL = 2;
    localparam int TLO   = DUMMY + LEADP + ACTP;
    localparam int LLEN  = TLO + TAILP;
    localparam int NPIX  = LLEN + 2;

    logic       clk = 1'b0;
    logic       rst;
    logic       line_start;
    logic       frame_start;
    logic       tail_en;
    logic       clamp_ob;
    logic       pix_blank;
    logic [1:0] seq_sel;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    ccd_hseq_ctrl #(
        .DUMMY_PIX     (DUMMY),
        .LEAD_OB_PIX   (LEADP),
        .ACTIVE_PIX    (ACTP),
        .TAIL_OB_PIX   (TAILP),
        .LEAD_OB_LINES (LEADL),
        .ACTIVE_LINES  (ACTL),
        .TAIL_OB_LINES (TAILL)
    ) u_ccd_hseq_ctrl (
        .clk             (clk),
        .rst             (rst),
        .line_start      (line_start),
        .frame_start     (frame_start),
        .tail_ob_seq2_en (tail_en),
        .clamp_ob        (clamp_ob),
        .pix_blank       (pix_blank),
        .seq_sel         (seq_sel)
    );

    // One segment: a run of lines sharing pulse, config and expected sequence.
    typedef struct packed {
        logic       fs;
        logic       cfg;
        logic [7:0] n;
        logic [1:0] seq;
    } seg_t;

    localparam int NSEG = 16;
    localparam seg_t SEGS [NSEG] = '{
        '{1'b0, 1'b1, 8'd2, 2'd1},  // 0  R1 lines before any frame
        '{1'b1, 1'b1, 8'd1, 2'd2},  // 1  R3 frame start, line 0
        '{1'b0, 1'b1, 8'd9, 2'd2},  // 2  R4 leading dark lines
        '{1'b0, 1'b1, 8'd3, 2'd3},  // 3  R4 image lines
        '{1'b0, 1'b1, 8'd2, 2'd2},  // 4  R8 tail lines, clamp enabled
        '{1'b0, 1'b1, 8'd2, 2'd1},  // 5  R3 saturated after frame
        '{1'b1, 1'b0, 8'd1, 2'd2},  // 6  second frame
        '{1'b0, 1'b0, 8'd9, 2'd2},  // 7
        '{1'b0, 1'b0, 8'd3, 2'd3},  // 8
        '{1'b0, 1'b0, 8'd2, 2'd1},  // 9  R8 tail lines, clamp disabled
        '{1'b0, 1'b0, 8'd1, 2'd1},  // 10
        '{1'b1, 1'b1, 8'd1, 2'd2},  // 11 third frame
        '{1'b0, 1'b1, 8'd4, 2'd2},  // 12
        '{1'b1, 1'b1, 8'd1, 2'd2},  // 13 R10 restart mid-frame
        '{1'b0, 1'b1, 8'd9, 2'd2},  // 14
        '{1'b0, 1'b1, 8'd1, 2'd3}   // 15 first image line of restarted frame
    };

    // Expected {clamp, blank, seq} for pixel p under sequence s (R5, R6, R7, R9).
    function automatic logic [3:0] model(input logic [1:0] s, input int p);
        logic c;
        logic b;
        c = (s == 2'd2) || ((s == 2'd3) && (p >= TLO) && (p < LLEN));
        b = (s == 2'd1);
        return {c, b, s};
    endfunction

    function automatic string seg_req(input int i, input logic [1:0] s);
        if (i == 0)  return "R1";
        if (i == 4 || i == 9) return "R8";
        if (i == 5)  return "R3";
        if (i == 13) return "R10";
        if (s == 2'd1) return "R4/R5";
        if (s == 2'd2) return "R4/R6";
        return "R4/R7";
    endfunction

    task automatic check(input string req, input int p, input logic [3:0] exp);
        logic [3:0] act;
        act = {clamp_ob, pix_blank, seq_sel};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s pixel %0d actual={clamp,blank,seq}=%b expected=%b",
                     req, p, act, exp);
        end
    endtask

    // R2: pixel 0 appears the cycle after the pulse edge, pixel p p cycles later.
    task automatic run_line(input logic fs, input logic cfg, input logic [1:0] s,
                            input int npix, input string req);
        @(negedge clk);
        line_start  = 1'b1;
        frame_start = fs;
        tail_en     = cfg;
        @(negedge clk);
        line_start  = 1'b0;
        frame_start = 1'b0;
        for (int p = 0; p < npix; p++) begin
            if (p > 0) @(negedge clk);
            check(req, p, model(s, p));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst         = 1'b1;
        line_start  = 1'b0;
        frame_start = 1'b0;
        tail_en     = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", 0, {1'b0, 1'b1, 2'd1});   // reset state while held
        rst = 1'b0;
        @(negedge clk);
        check("R1", 0, {1'b0, 1'b1, 2'd1});   // idle after release

        for (int i = 0; i < NSEG; i++) begin
            for (int k = 0; k < int'(SEGS[i].n); k++)
                run_line(SEGS[i].fs, SEGS[i].cfg, SEGS[i].seq, NPIX,
                         seg_req(i, SEGS[i].seq));
        end

        // R9: overlong image line, position holds at the end with clamp low
        run_line(1'b0, 1'b1, 2'd3, LLEN + 300, "R9");

        // R1: reset in mid-frame returns to the idle pattern
        run_line(1'b1, 1'b1, 2'd2, 20, "R10");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1", 0, {1'b0, 1'b1, 2'd1});
        run_line(1'b0, 1'b1, 2'd1, NPIX, "R1");
        run_line(1'b1, 1'b0, 2'd2, NPIX, "R3");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule